// File: doc/BRIEF.md
# Priority Interrupt Restart-Opcode Driver

This block is a small interrupt controller for an 8-bit CPU that vectors through one-byte restart instructions. Eight level-sensitive request lines come in, each tied to one of eight fixed low-memory entry points. A CPU-written mask register can block any line. Among the unblocked lines that are active, a priority encoder picks the highest-numbered one, and the resulting index is held in a register. While any unblocked request is present, the block raises its interrupt output to the CPU.

When the CPU answers with its acknowledge strobe, the block drives a restart opcode onto the data bus. The opcode has the form `11nnn111`, where `nnn` is the held index. The index is frozen from the first clock edge at which the acknowledge is seen, so the byte on the bus cannot change in the middle of the cycle. Outside the acknowledge cycle the bus driver is disabled, and the data output is held at zero so that a bus-level tri-state buffer can use it directly.

A request source must hold its line until its own service routine clears it. The block keeps no record of pending or in-service requests. All pins are plain control or status pins. No part of the interface is a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `rst_vec_jammer`

## Requirements
- R1: After reset the mask register holds all ones, so every line is blocked: `int_o`, `data_oe` and `data_o` are all 0, even with every request line high.
- R2: When `mask_wr_en` is high at a rising clock edge, `mask_wr_data` is loaded into the mask. A mask bit at 1 blocks the request line with the same bit number.
- R3: `int_o` is high in the cycle after a rising edge at which at least one unblocked request was high. It is low in the cycle after an edge at which none was.
- R4: When several unblocked lines are active together, the highest-numbered line is selected: line 7 has the highest priority and line 0 the lowest. With no unblocked line active, the held index is 0.
- R5: While `inta_i` is high, `data_oe` is 1 and `data_o` equals `{2'b11, idx[2:0], 3'b111}`, where `idx` is the held index. For example, line 7 gives 8'hFF, line 2 gives 8'hD7 and line 0 gives 8'hC7.
- R6: While `inta_i` is low, `data_oe` is 0 and `data_o` is 8'h00.
- R7: The held index is the one captured at the last rising edge before `inta_i` went high. It does not change while `inta_i` stays high, even if requests or the mask change.
- R8: A blocked line is never selected, even when it is the highest-numbered active line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Level-sensitive request lines, bit n for restart vector n |
| mask_wr_en | input | 1 | Load strobe for the mask register |
| mask_wr_data | input | 8 | New mask value, 1 blocks a line |
| inta_i | input | 1 | Interrupt acknowledge from the CPU |
| int_o | output | 1 | Interrupt request to the CPU |
| data_o | output | 8 | Restart opcode for the data bus, zero when idle |
| data_oe | output | 1 | Data bus driver enable |

## Verification
The bench builds the block with its default parameters: eight request lines, a 3-bit index and an 8-bit bus. At this size the whole request space is small enough that random request words, combined with random mask words, reach every priority pairing, and every case where a blocked high line sits above an unblocked lower one. Directed cases cover the reset state, the two extreme lines, acknowledging with nothing pending, and requests and mask changing during a held acknowledge.

// File: rtl/rvj_pkg.sv
package rvj_pkg;
  // index width fixes the number of restart vectors
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned REQ_N  = 1 << IDX_W;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned PRE_W  = 2;
  localparam int unsigned POST_W = BUS_W - PRE_W - IDX_W;

  // build the restart opcode: prefix ones, index, suffix ones
  function automatic logic [BUS_W-1:0] rst_opcode(input logic [IDX_W-1:0] idx);
    return {{PRE_W{1'b1}}, idx, {POST_W{1'b1}}};
  endfunction
endpackage

// File: rtl/rvj_mask_reg.sv
module rvj_mask_reg #(
  parameter int unsigned N = rvj_pkg::REQ_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  input  logic [N-1:0] req,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] active
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= '1;
    else if (wr_en) mask_q <= wr_data;
  end

  assign active = req & ~mask_q;
endmodule

// File: rtl/rvj_prio_enc.sv
module rvj_prio_enc #(
  parameter int unsigned IW = rvj_pkg::IDX_W,
  localparam int unsigned N = 1 << IW
) (
  input  logic [N-1:0]  act,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] win;

  // a line wins when it is active and no higher line is
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_win
      if (g == N-1) begin : g_top
        assign win[g] = act[g];
      end else begin : g_low
        assign win[g] = act[g] & ~(|act[N-1:g+1]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (win[i]) idx = idx | IW'(i);
    end
  end

  assign any = |act;
endmodule

// File: rtl/rvj_vec_latch.sv
module rvj_vec_latch #(
  parameter int unsigned IW = rvj_pkg::IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          any,
  input  logic [IW-1:0] idx,
  output logic          int_q,
  output logic [IW-1:0] idx_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q <= 1'b0;
      idx_q <= '0;
    end else begin
      int_q <= any;
      if (!hold) idx_q <= idx;
    end
  end
endmodule

// File: rtl/rst_vec_jammer.sv
module rst_vec_jammer
  import rvj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_N-1:0] irq_req,
  input  logic             mask_wr_en,
  input  logic [REQ_N-1:0] mask_wr_data,
  input  logic             inta_i,
  output logic             int_o,
  output logic [BUS_W-1:0] data_o,
  output logic             data_oe
);
  logic [REQ_N-1:0] mask_q;
  logic [REQ_N-1:0] active;
  logic             any_act;
  logic [IDX_W-1:0] enc_idx;
  logic [IDX_W-1:0] held_idx;

  rvj_mask_reg #(.N(REQ_N)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr_en), .wr_data(mask_wr_data),
    .req(irq_req), .mask_q(mask_q), .active(active)
  );

  rvj_prio_enc #(.IW(IDX_W)) u_enc (
    .act(active), .any(any_act), .idx(enc_idx)
  );

  rvj_vec_latch #(.IW(IDX_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .hold(inta_i), .any(any_act),
    .idx(enc_idx), .int_q(int_o), .idx_q(held_idx)
  );

  assign data_oe = inta_i;
  assign data_o  = inta_i ? rst_opcode(held_idx) : '0;
endmodule

// File: rtl/rvj_chk.sv
module rvj_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] irq_req,
  input logic [7:0] mask_q,
  input logic       mask_wr_en,
  input logic [7:0] mask_wr_data,
  input logic       inta_i,
  input logic       int_o,
  input logic [7:0] data_o,
  input logic       data_oe
);
  logic [7:0] act_w;
  assign act_w = irq_req & ~mask_q;

  a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mask_wr_en) && $past(rst_n) |-> mask_q == $past(mask_wr_data));

  a_r3_int_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int_o == $past(|act_w));

  a_r4_r8_top_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inta_i) && int_o |-> ($past(act_w) >> data_o[5:3]) == 8'd1);

  a_r5_opcode_shape: assert property (@(posedge clk) disable iff (!rst_n)
    inta_i |-> data_oe && data_o[7:6] == 2'b11 && data_o[2:0] == 3'b111);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !inta_i |-> !data_oe && data_o == 8'h00);

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    inta_i && $past(inta_i) |-> $stable(data_o));
endmodule

bind rst_vec_jammer rvj_chk chk_i (.*);

// File: tb/rst_vec_jammer_tb.sv
module rst_vec_jammer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_req;
  logic       mask_wr_en;
  logic [7:0] mask_wr_data;
  logic       inta_i;
  logic       int_o;
  logic [7:0] data_o;
  logic       data_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_vec_jammer dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_wr_en(mask_wr_en),
    .mask_wr_data(mask_wr_data), .inta_i(inta_i), .int_o(int_o),
    .data_o(data_o), .data_oe(data_oe)
  );

  function automatic logic [7:0] exp_op(input logic [7:0] act);
    logic [2:0] n;
    n = 3'd0;
    for (int i = 0; i < 8; i++) if (act[i]) n = 3'(i);
    return {2'b11, n, 3'b111};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_mask(input logic [7:0] m);
    @(negedge clk);
    mask_wr_en = 1'b1; mask_wr_data = m;
    @(negedge clk);
    mask_wr_en = 1'b0;
    m_mask = m;
  endtask

  // apply requests, wait one edge, check the interrupt output (R3)
  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq_req = v;
    @(negedge clk);
    check("R3 int_o", {7'd0, int_o}, {7'd0, |(v & ~m_mask)});
  endtask

  // acknowledge cycle: opcode, freeze under new stimulus, release
  task automatic ack(input string req, input logic [7:0] chg);
    logic [7:0] e;
    e = exp_op(irq_req & ~m_mask);
    @(negedge clk);
    inta_i = 1'b1;
    #1;
    check("R5 data_oe", {7'd0, data_oe}, 8'd1);
    check(req, data_o, e);
    irq_req = chg;
    @(negedge clk);
    #1;
    check("R7 frozen", data_o, e);
    inta_i = 1'b0;
    #1;
    check("R6 idle", {data_oe, data_o[7:1]}, 8'd0);
    check("R6 idle lsb", {7'd0, data_o[0]}, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; irq_req = 8'hFF; mask_wr_en = 1'b0; mask_wr_data = 8'h00;
    inta_i = 1'b0; m_mask = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1: all lines blocked after reset
    check("R1 int_o", {7'd0, int_o}, 8'd0);
    check("R1 data_oe", {7'd0, data_oe}, 8'd0);
    check("R1 data_o", data_o, 8'h00);

    // R2: open all lines
    wr_mask(8'h00);
    set_irq(8'h81);
    ack("R4 line7", 8'h01);
    set_irq(8'h06);
    ack("R4 line2", 8'h00);
    set_irq(8'h01);
    ack("R4 line0", 8'hF0);
    // R8: blocked top line
    wr_mask(8'h80);
    set_irq(8'h81);
    ack("R8 blocked top", 8'h81);
    // R2: mask blocks everything
    wr_mask(8'hFF);
    set_irq(8'h7E);
    check("R2 mask all", {7'd0, int_o}, 8'd0);
    // R4: nothing pending gives index 0
    ack("R4 none", 8'h00);
    // R7: mask change during acknowledge
    wr_mask(8'h00);
    set_irq(8'h10);
    @(negedge clk);
    inta_i = 1'b1;
    mask_wr_en = 1'b1; mask_wr_data = 8'hFF;
    #1;
    check("R7 before", data_o, 8'hE7);
    @(negedge clk);
    mask_wr_en = 1'b0; m_mask = 8'hFF;
    irq_req = 8'h80;
    @(negedge clk);
    #1;
    check("R7 mask change", data_o, 8'hE7);
    inta_i = 1'b0;

    // random phase
    for (int k = 0; k < 300; k++) begin
      if (k % 5 == 0) wr_mask(8'($urandom));
      set_irq(8'($urandom));
      ack("R4 R8 random", 8'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule